// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Controller

This block watches a small group of general-purpose input pins and raises an interrupt request when a pin makes a transition that software has asked to see. Every pin has two independent enables, one for low-to-high and one for high-to-low transitions. When an enabled transition arrives, a sticky per-pin flag is set and stays set until software clears it. A pin with both enables set flags on any change. A pin with neither enable set is not watched.

Pin inputs are asynchronous to the block clock. Each one passes through a synchronizer chain before edge detection. Software reaches three byte-wide registers through a simple strobe-and-address port with combinational read data: the rising enables, the falling enables and the flags. The interrupt output is the OR of all flags, qualified by a single enable input.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, all three registers read 0 and irq_o is low.
- R2: With bit n of the rising-enable register (address 0) set, a low-to-high change on pin_i[n] sets flag bit n on the third rising clock edge after the change. The flag is still 0 after the second edge. A high-to-low change does not set it.
- R3: With bit n of the falling-enable register (address 1) set, a high-to-low change on pin_i[n] sets flag bit n on the third rising clock edge. A low-to-high change does not set it.
- R4: With both enables of a pin set, either direction of change sets its flag. With neither enable set, no change on that pin sets its flag.
- R5: Flag bits (address 2) stay set until software writes 0 to that bit position. Writing 1 to a flag bit leaves it unchanged, and the pin returning to its old level does not clear it.
- R6: When an enabled edge sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R7: irq_o is high exactly when irq_en_i is high and at least one flag bit is set.
- R8: Register bits 7 and 6 always read 0 and ignore writes. Address 3 reads 0 and writes to it change nothing.
- R9: A write to address 0 or 1 stores wr_data_i[5:0], and that value reads back on rd_data_o[5:0] at the same address.
- R10: An enabled edge on one pin sets only that pin's flag bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | Asynchronous pin levels |
| irq_en_i | input | 1 | Interrupt output enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 rising, 1 falling, 2 flags |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: six pins, an 8-bit data path and a two-stage synchronizer. These defaults make the three-edge detection latency exact, so the bench samples on both sides of it. They also put pin 5 at the top implemented bit and leave bits 7 and 6 as real unimplemented positions to probe. With a two-stage chain, a software clear can be lined up against the cycle in which an edge is recorded, so the set-versus-clear collision can be checked.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] d;
    if (s == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import pin_irq_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] fall_i,
  output logic [WIDTH-1:0] rise_en_o,
  output logic [WIDTH-1:0] fall_en_o,
  output logic [WIDTH-1:0] flag_o,
  output logic [WIDTH-1:0] set_o
);
  logic [WIDTH-1:0] rise_en_q, fall_en_q, flag_q, flag_d;
  logic wr_rise, wr_fall, wr_flag;

  assign wr_rise = wr_en_i && (sel_i == SEL_RISE);
  assign wr_fall = wr_en_i && (sel_i == SEL_FALL);
  assign wr_flag = wr_en_i && (sel_i == SEL_FLAG);

  assign set_o = (rise_i & rise_en_q) | (fall_i & fall_en_q);

  // write-0 clears, write-1 keeps; hardware set applied last so it wins
  always_comb begin
    flag_d = flag_q;
    if (wr_flag) flag_d = flag_d & wr_data_i;
    flag_d = flag_d | set_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      flag_q    <= '0;
    end else begin
      if (wr_rise) rise_en_q <= wr_data_i;
      if (wr_fall) fall_en_q <= wr_data_i;
      flag_q <= flag_d;
    end
  end

  assign rise_en_o = rise_en_q;
  assign fall_en_o = fall_en_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                irq_en_i,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_sync_w, rise_w, fall_w;
  logic [NUM_PINS-1:0] rise_en_w, fall_en_w, flag_w, set_w;
  reg_sel_e            sel_w;

  assign sel_w = reg_sel_e'(addr_i);

  if (DATA_W > NUM_PINS) begin : g_hi_bits
    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data_i[DATA_W-1:NUM_PINS];
  end

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (pin_sync_w)
  );

  edge_detect #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(pin_sync_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  irq_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .sel_i    (sel_w),
    .wr_data_i(wr_data_i[NUM_PINS-1:0]),
    .rise_i   (rise_w),
    .fall_i   (fall_w),
    .rise_en_o(rise_en_w),
    .fall_en_o(fall_en_w),
    .flag_o   (flag_w),
    .set_o    (set_w)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (sel_w)
      SEL_RISE: rd_data_o = DATA_W'(rise_en_w);
      SEL_FALL: rd_data_o = DATA_W'(fall_en_w);
      SEL_FLAG: rd_data_o = DATA_W'(flag_w);
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_en_i && (|flag_w);
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
  parameter int NUM_PINS = 6,
  parameter int DATA_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                irq_en_i,
  input logic                wr_en_i,
  input logic [1:0]          addr_i,
  input logic [DATA_W-1:0]   rd_data_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] set_i,
  input logic [NUM_PINS-1:0] flag_i,
  input logic [NUM_PINS-1:0] rise_en_i
);
  // R7
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_i);

  // R8
  hi_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:NUM_PINS] == '0);

  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd2) |=> ((flag_i & $past(flag_i)) == $past(flag_i)));

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_i & $past(set_i)) == $past(set_i)));

  // R4
  no_spurious_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((flag_i & ~$past(flag_i)) == '0));

  // R9
  rise_en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd0) |=> $stable(rise_en_i));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_en_i (irq_en_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o),
  .set_i    (set_w),
  .flag_i   (flag_w),
  .rise_en_i(rise_en_w)
);

// File: tb/tb_pin_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pin_irq_ctrl;
  localparam int NP = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '0;
  logic          irq_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_irq_ctrl #(.NUM_PINS(NP), .DATA_W(DW), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .irq_en_i(irq_en),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_pin(int idx, logic v);
    @(negedge clk);
    pin[idx] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(2'd0, d); check("R1 rise reg", d, 8'h00);
    rd(2'd1, d); check("R1 fall reg", d, 8'h00);
    rd(2'd2, d); check("R1 flag reg", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_map();
    logic [DW-1:0] d;
    wr(2'd0, 8'h2A); rd(2'd0, d); check("R9 rise readback", d, 8'h2A);
    wr(2'd1, 8'hFF); rd(2'd1, d); check("R8 fall upper bits", d, 8'h3F);
    wr(2'd0, 8'hC0); rd(2'd0, d); check("R8 rise upper bits", d, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R8 addr3 read", d, 8'h00);
    rd(2'd1, d); check("R8 addr3 write ignored", d, 8'h3F);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_rise();
    logic [DW-1:0] d;
    wr(2'd0, 8'h01);
    drive_pin(0, 1'b1);
    repeat (2) @(posedge clk);
    rd(2'd2, d); check("R2 flag before third edge", d, 8'h00);
    @(posedge clk);
    rd(2'd2, d); check("R2 flag at third edge", d, 8'h01);
    wr(2'd2, 8'h00);
    drive_pin(0, 1'b0); settle();
    rd(2'd2, d); check("R2 falling ignored", d, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_fall();
    logic [DW-1:0] d;
    wr(2'd1, 8'h20);
    drive_pin(5, 1'b1); settle();
    rd(2'd2, d); check("R3 rising ignored", d, 8'h00);
    drive_pin(5, 1'b0);
    repeat (2) @(posedge clk);
    rd(2'd2, d); check("R3 flag before third edge", d, 8'h00);
    @(posedge clk);
    rd(2'd2, d); check("R3 flag on pin 5", d, 8'h20);
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic t_both();
    logic [DW-1:0] d;
    wr(2'd0, 8'h04); wr(2'd1, 8'h04);
    drive_pin(2, 1'b1); settle();
    rd(2'd2, d); check("R4 both rise", d, 8'h04);
    wr(2'd2, 8'h00);
    drive_pin(2, 1'b0); settle();
    rd(2'd2, d); check("R4 both fall", d, 8'h04);
    wr(2'd2, 8'h00);
    drive_pin(3, 1'b1); settle(); drive_pin(3, 1'b0); settle();
    rd(2'd2, d); check("R4 unenabled pin", d, 8'h00);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] d;
    wr(2'd0, 8'h12);
    drive_pin(1, 1'b1); drive_pin(4, 1'b1); settle();
    drive_pin(1, 1'b0); drive_pin(4, 1'b0); settle();
    rd(2'd2, d); check("R5 flags held after pin returns", d, 8'h12);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R5 write 1 no effect", d, 8'h12);
    wr(2'd2, 8'hFD);
    rd(2'd2, d); check("R5 write 0 clears one bit", d, 8'h10);
    irq_en = 1'b0; #1;
    check("R7 irq gated off", {7'd0, irq}, 8'h00);
    irq_en = 1'b1; #1;
    check("R7 irq on", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h00); #1;
    check("R7 irq off after clear", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    wr(2'd0, 8'h08);
    drive_pin(3, 1'b1);
    repeat (2) @(posedge clk);
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R6 set wins over clear", d, 8'h08);
    wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    drive_pin(3, 1'b0); settle();
  endtask

  task automatic t_indep();
    logic [DW-1:0] d;
    wr(2'd0, 8'h3F);
    drive_pin(3, 1'b1); settle();
    rd(2'd2, d); check("R10 only pin 3 flagged", d, 8'h08);
    drive_pin(3, 1'b0);
    wr(2'd2, 8'h00); wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_both();
    t_sticky();
    t_collide();
    t_indep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule